// File: doc/BRIEF.md
# Out-of-Order Atomic Reservation Station

This block sits in front of a slow memory port whose read round trip is long, often tens of cycles, and serves atomic fetch-and-add requests on hashed keys. Each key that has a memory read outstanding owns one reservation slot. A later request for that key is queued inside the slot instead of causing a second read. A request for any other key takes a free slot and sends its read at once, so one slow key never holds up the rest of the traffic.

When the read data for a slot comes back, the slot keeps the value locally. It then runs its queued operations one per cycle against that copy. Each response carries the request tag and the value as it stood before that operation was applied. Once the queue is empty, the slot writes the final value back to memory once and is released. Responses for different keys can leave in any order relative to their arrival. Responses for one key always leave in arrival order.

Top module: `atomic_rsv_station`

## Requirements
- R1: A request accepted for a key held by no slot produces, in the next cycle, exactly one memory read carrying that key and the index of the slot it was given. The lowest-numbered free slot is used.
- R2: A request accepted for a key that a slot already holds issues no memory read. At no time do two slots hold the same key.
- R3: While one key waits on memory, a request for a different key is accepted and its read issues in the next cycle.
- R4: Opcode 1 adds the operand to the stored value, modulo 2^DATA_W. Opcode 0 reads and leaves the value unchanged. Each response carries the request's tag and the value before the operation.
- R5: Responses for one key leave in the order their requests were accepted. Responses for different keys may leave out of arrival order. When several slots are ready in the same cycle, the lowest slot index goes first, and at most one response leaves per cycle.
- R6: After a slot's last queued operation, exactly one memory write carries the slot's key and final value, and the slot becomes free. Memory then holds the result of applying every request to that key in arrival order.
- R7: `req_ready_o` is low when the key is held by no slot and all 8 slots are occupied. It is also low when the matching slot already holds 4 queued operations.
- R8: During reset, `req_ready_o` is high and `rsp_valid_o`, `mem_rd_valid_o` and `mem_wr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_tag_i | input | TAG_W | Request tag, returned in the response |
| req_key_i | input | KEY_W | Key hash |
| req_op_i | input | 1 | 1 = fetch-and-add, 0 = fetch only |
| req_operand_i | input | DATA_W | Addend |
| mem_rd_valid_o | output | 1 | Memory read issued |
| mem_rd_key_o | output | KEY_W | Key to read |
| mem_rd_slot_o | output | SLOT_W | Slot that will receive the data |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_slot_i | input | SLOT_W | Slot the data belongs to |
| mem_rsp_data_i | input | DATA_W | Stored value |
| mem_wr_valid_o | output | 1 | Write-back issued |
| mem_wr_key_o | output | KEY_W | Key to write |
| mem_wr_data_o | output | DATA_W | Final value |
| rsp_valid_o | output | 1 | Response present |
| rsp_tag_o | output | TAG_W | Tag of the answered request |
| rsp_data_o | output | DATA_W | Value before the operation |

## Verification
The hardest case to reach is back-pressure from a full slot queue, or from a full slot table, while reads are still outstanding. Only a memory model with long, key-dependent latency keeps slots occupied long enough to get there. The bench's memory model delays each read by 8 + 2·key cycles. With that delay, eight distinct keys followed by three more requests to the slowest key fill both the table and one queue before any data returns. The same delay lets a slow key sent first be overtaken by a fast key sent second. A long randomized run then mixes the two opcodes over 16 keys, so that slots are reused right after their write-back.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_DRAIN = 2'd2
  } slot_state_e;

  localparam logic OP_READ = 1'b0;
  localparam logic OP_ADD  = 1'b1;
endpackage

// File: rtl/rs_pick_first.sv
module rs_pick_first #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rs_op_fifo.sv
module rs_op_fifo #(
  parameter int WIDTH = 37,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/atomic_rsv_station.sv
module atomic_rsv_station
  import rs_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 8,
  parameter int DEPTH  = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [KEY_W-1:0]  req_key_i,
  input  logic              req_op_i,
  input  logic [DATA_W-1:0] req_operand_i,
  output logic              mem_rd_valid_o,
  output logic [KEY_W-1:0]  mem_rd_key_o,
  output logic [SLOT_W-1:0] mem_rd_slot_o,
  input  logic              mem_rsp_valid_i,
  input  logic [SLOT_W-1:0] mem_rsp_slot_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              mem_wr_valid_o,
  output logic [KEY_W-1:0]  mem_wr_key_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int ENT_W = TAG_W + 1 + DATA_W;

  slot_state_e       state_q [SLOTS];
  logic [KEY_W-1:0]  key_q   [SLOTS];
  logic [DATA_W-1:0] val_q   [SLOTS];
  logic [ENT_W-1:0]  head    [SLOTS];

  logic [SLOTS-1:0] busy, hit, push, pop, empty, full, drain_rdy, wb_rdy;
  logic [SLOT_W-1:0] free_idx, exec_idx, wb_idx;
  logic free_any, exec_any, wb_any, any_hit, accept;
  logic [ENT_W-1:0]  exec_ent;
  logic [DATA_W-1:0] exec_pre, exec_new;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      busy[i] = (state_q[i] != SLOT_FREE);
      hit[i]  = busy[i] && (key_q[i] == req_key_i);
    end
  end

  assign any_hit     = |hit;
  assign req_ready_o = any_hit ? ~|(hit & full) : free_any;
  assign accept      = req_valid_i && req_ready_o;

  rs_pick_first #(.N(SLOTS), .IDX_W(SLOT_W)) u_pick_free (
    .req_i(~busy), .idx_o(free_idx), .any_o(free_any));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      push[i]      = accept && (any_hit ? hit[i] : (free_idx == SLOT_W'(i)));
      drain_rdy[i] = (state_q[i] == SLOT_DRAIN) && !empty[i];
      // a slot taking a new entry this cycle must not retire
      wb_rdy[i]    = (state_q[i] == SLOT_DRAIN) && empty[i] && !push[i];
    end
  end

  rs_pick_first #(.N(SLOTS), .IDX_W(SLOT_W)) u_pick_exec (
    .req_i(drain_rdy), .idx_o(exec_idx), .any_o(exec_any));

  rs_pick_first #(.N(SLOTS), .IDX_W(SLOT_W)) u_pick_wb (
    .req_i(wb_rdy), .idx_o(wb_idx), .any_o(wb_any));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) pop[i] = exec_any && (exec_idx == SLOT_W'(i));
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rs_op_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[g]),
      .data_i  ({req_tag_i, req_op_i, req_operand_i}),
      .pop_i   (pop[g]),
      .data_o  (head[g]),
      .empty_o (empty[g]),
      .full_o  (full[g])
    );
  end

  assign exec_ent = head[exec_idx];
  assign exec_pre = val_q[exec_idx];
  assign exec_new = (exec_ent[DATA_W] == OP_ADD) ? exec_pre + exec_ent[DATA_W-1:0] : exec_pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) begin
        state_q[i] <= SLOT_FREE;
        key_q[i]   <= '0;
        val_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (push[i] && !any_hit) begin
          state_q[i] <= SLOT_WAIT;
          key_q[i]   <= req_key_i;
        end
        if (mem_rsp_valid_i && mem_rsp_slot_i == SLOT_W'(i)) begin
          state_q[i] <= SLOT_DRAIN;
          val_q[i]   <= mem_rsp_data_i;
        end
        if (pop[i]) val_q[i] <= exec_new;
        if (wb_any && wb_idx == SLOT_W'(i)) state_q[i] <= SLOT_FREE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_valid_o <= 1'b0;
      mem_rd_key_o   <= '0;
      mem_rd_slot_o  <= '0;
      mem_wr_valid_o <= 1'b0;
      mem_wr_key_o   <= '0;
      mem_wr_data_o  <= '0;
      rsp_valid_o    <= 1'b0;
      rsp_tag_o      <= '0;
      rsp_data_o     <= '0;
    end else begin
      mem_rd_valid_o <= accept && !any_hit;
      mem_rd_key_o   <= req_key_i;
      mem_rd_slot_o  <= free_idx;
      mem_wr_valid_o <= wb_any;
      mem_wr_key_o   <= key_q[wb_idx];
      mem_wr_data_o  <= val_q[wb_idx];
      rsp_valid_o    <= exec_any;
      rsp_tag_o      <= exec_ent[ENT_W-1 -: TAG_W];
      rsp_data_o     <= exec_pre;
    end
  end

  p_rd_on_new_key_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !any_hit) |=> (mem_rd_valid_o && mem_rd_key_o == $past(req_key_i)));
  p_no_rd_on_held_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && any_hit) |=> !mem_rd_valid_o);
  p_key_unique_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_rsp_to_waiting_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> (state_q[mem_rsp_slot_i] == SLOT_WAIT));
endmodule

// File: tb/atomic_rsv_station_tb_top.sv
module atomic_rsv_station_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [3:0]  req_tag_i = '0;
  logic [15:0] req_key_i = '0;
  logic        req_op_i = 1'b0;
  logic [31:0] req_operand_i = '0;
  logic        mem_rd_valid_o;
  logic [15:0] mem_rd_key_o;
  logic [2:0]  mem_rd_slot_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [2:0]  mem_rsp_slot_i = '0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        mem_wr_valid_o;
  logic [15:0] mem_wr_key_o;
  logic [31:0] mem_wr_data_o;
  logic        rsp_valid_o;
  logic [3:0]  rsp_tag_o;
  logic [31:0] rsp_data_o;

  // 8 ns period, 125 MHz
  always #4 clk = ~clk;

  atomic_rsv_station dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_tag_i(req_tag_i),
    .req_key_i(req_key_i), .req_op_i(req_op_i), .req_operand_i(req_operand_i),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_key_o(mem_rd_key_o), .mem_rd_slot_o(mem_rd_slot_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_slot_i(mem_rsp_slot_i), .mem_rsp_data_i(mem_rsp_data_i),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_key_o(mem_wr_key_o), .mem_wr_data_o(mem_wr_data_o),
    .rsp_valid_o(rsp_valid_o), .rsp_tag_o(rsp_tag_o), .rsp_data_o(rsp_data_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem_m  [16];
  logic [31:0] ref_m  [16];
  int rd_cnt [16], wr_cnt [16], got_rsp [16];
  logic [35:0] exp_q [16][$];
  logic [15:0] tag_busy = '0;
  int tag_key [16];
  int next_tag = 0;
  int rsp_log [$];
  logic       pend_v [8];
  int         pend_k [8], pend_c [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model and response monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_valid_o) begin
        mem_m[mem_wr_key_o[3:0]] = mem_wr_data_o;
        wr_cnt[mem_wr_key_o[3:0]]++;
      end
      if (mem_rd_valid_o) begin
        pend_v[mem_rd_slot_o] = 1'b1;
        pend_k[mem_rd_slot_o] = int'(mem_rd_key_o[3:0]);
        pend_c[mem_rd_slot_o] = 8 + 2 * int'(mem_rd_key_o[3:0]);
        rd_cnt[mem_rd_key_o[3:0]]++;
      end
      for (int s = 0; s < 8; s++) if (pend_v[s] && pend_c[s] > 0) pend_c[s]--;
      mem_rsp_valid_i = 1'b0;
      for (int s = 0; s < 8; s++) begin
        if (!mem_rsp_valid_i && pend_v[s] && pend_c[s] == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_slot_i  = 3'(s);
          mem_rsp_data_i  = mem_m[pend_k[s]];
          pend_v[s]       = 1'b0;
        end
      end
      if (rsp_valid_o) begin
        int k;
        logic [35:0] e;
        rsp_log.push_back(int'(rsp_tag_o));
        if (!tag_busy[rsp_tag_o]) begin
          chk(1'b0, "R4", "response with idle tag", rsp_tag_o, -1);
        end else begin
          k = tag_key[rsp_tag_o];
          got_rsp[k]++;
          e = exp_q[k].pop_front();
          tag_busy[rsp_tag_o] = 1'b0;
          chk(e[35:32] == rsp_tag_o, "R5", "per-key response order, tag", rsp_tag_o, e[35:32]);
          chk(e[31:0] == rsp_data_o, "R4", "pre-op value", rsp_data_o, e[31:0]);
        end
      end
    end
  end

  task automatic send(input int key, input bit op, input logic [31:0] opnd);
    int t;
    @(negedge clk);
    while (tag_busy[next_tag]) @(negedge clk);
    t = next_tag;
    req_valid_i = 1'b1; req_tag_i = 4'(t); req_key_i = 16'(key);
    req_op_i = op; req_operand_i = opnd;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    tag_busy[t] = 1'b1;
    tag_key[t]  = key;
    exp_q[key].push_back({4'(t), ref_m[key]});
    if (op) ref_m[key] = ref_m[key] + opnd;
    next_tag = (next_tag + 1) % 16;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic probe_ready(input int key, output logic rdy);
    @(negedge clk);
    req_valid_i = 1'b1; req_key_i = 16'(key); req_tag_i = 4'(next_tag);
    #1;
    rdy = req_ready_o;
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (|tag_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic rdy;
    for (int k = 0; k < 16; k++) begin
      mem_m[k] = 32'(k * 100); ref_m[k] = 32'(k * 100);
      rd_cnt[k] = 0; wr_cnt[k] = 0; got_rsp[k] = 0;
    end
    for (int s = 0; s < 8; s++) begin pend_v[s] = 1'b0; pend_k[s] = 0; pend_c[s] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk(req_ready_o == 1'b1, "R8", "ready in reset", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R8", "rsp_valid in reset", rsp_valid_o, 0);
    chk(mem_rd_valid_o == 1'b0 && mem_wr_valid_o == 1'b0, "R8", "mem valids in reset",
        mem_rd_valid_o | mem_wr_valid_o, 0);
    rst_n = 1'b1;

    // R1: new key reads next cycle, slot 0
    send(3, 1'b1, 32'd5);
    @(negedge clk); #1;
    chk(mem_rd_valid_o && mem_rd_key_o == 16'd3, "R1", "read for key 3", mem_rd_key_o, 3);
    chk(mem_rd_slot_o == 3'd0, "R1", "lowest free slot", mem_rd_slot_o, 0);
    // R2: second op on key 3 parks, no read
    send(3, 1'b1, 32'd7);
    @(negedge clk); #1;
    chk(!mem_rd_valid_o, "R2", "no read for held key", mem_rd_valid_o, 0);
    // R3: other key goes to memory while key 3 waits
    send(4, 1'b0, 32'd99);
    @(negedge clk); #1;
    chk(mem_rd_valid_o && mem_rd_key_o == 16'd4, "R3", "read for key 4", mem_rd_key_o, 4);
    chk(got_rsp[3] == 0, "R3", "key 3 still waiting", got_rsp[3], 0);
    drain();
    chk(rd_cnt[3] == 1, "R2", "reads for key 3", rd_cnt[3], 1);
    chk(wr_cnt[3] == 1, "R6", "write-backs for key 3", wr_cnt[3], 1);
    chk(mem_m[3] == 32'd312, "R6", "final value key 3", mem_m[3], 312);
    chk(mem_m[4] == 32'd400, "R4", "read op leaves key 4", mem_m[4], 400);

    // R5: slow key sent first is overtaken by fast key
    rsp_log.delete();
    send(9, 1'b1, 32'd1);
    send(1, 1'b1, 32'd1);
    drain();
    chk(rsp_log.size() == 2 && rsp_log[0] == (next_tag + 15) % 16, "R5", "fast key answered first",
        rsp_log.size() > 0 ? rsp_log[0] : -1, (next_tag + 15) % 16);

    // R7: fill all slots, then a slot queue
    for (int k = 8; k < 16; k++) send(k, 1'b1, 32'(k));
    probe_ready(0, rdy);
    chk(rdy == 1'b0, "R7", "ready with all slots busy", rdy, 0);
    probe_ready(14, rdy);
    chk(rdy == 1'b1, "R7", "ready for held key with room", rdy, 1);
    for (int j = 0; j < 3; j++) send(15, 1'b1, 32'hFFFF_FFFF);
    probe_ready(15, rdy);
    chk(rdy == 1'b0, "R7", "ready with full slot queue", rdy, 0);
    drain();
    chk(mem_m[15] == 32'd1512, "R4", "wraparound add key 15", mem_m[15], 1512);

    // randomized mix
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom % 16), 1'($urandom % 4 != 0), $urandom);
      if ($urandom % 5 == 0) @(negedge clk);
    end
    drain();
    for (int k = 0; k < 16; k++)
      chk(mem_m[k] == ref_m[k], "R6", "memory matches sequential result", mem_m[k], ref_m[k]);
    for (int k = 0; k < 16; k++)
      chk(exp_q[k].size() == 0, "R4", "missing responses", exp_q[k].size(), 0);
    finish_run();
  end
endmodule